// File: doc/BRIEF.md
# One-Wire Bus Master

This block is the master side of a single-wire, open-drain serial bus. It produces the two kinds of bus action that higher layers need: a bus reset followed by a check for a slave's presence answer, and a single-bit time slot. A bit slot either writes a zero or writes a one, and the write-one slot also reads the bit that a slave returns. Byte assembly, ROM search, CRC and interrupts are left to software.

Software programs a clock divider so that the block produces a 1 µs tick. It then starts each action by writing a command bit into the control register. The command bit reads back as set for as long as the action runs and clears itself when the action ends. The status bits that an action produces are valid once its command bit has cleared.

The pad is modelled as a drive-low enable (`bus_drive_low`) and the sampled line level (`bus_in`). Outside the line pull-up makes the line read high when no one drives it. Register access is a plain single-cycle write strobe, and read data follows the address combinationally. No stream interface is involved, so there is no back-pressure.

Top module: `onewire_master`

## Requirements
- R1: The registers are byte wide and sit at these addresses: control at 0x0, divider at 0x2 (read/write), soft reset at 0x4 (bit 0, read/write). Every register reads 0 after power-on reset. Any other address reads 0.
- R2: One tick lasts (divider + 1) clock cycles. The divider restarts when an action starts, so an action lasting N ticks keeps its command bit set for exactly N·(divider+1) cycles.
- R3: Writing 1 to control bit 7 starts a reset/presence sequence. Bit 7 reads 1 for 1023 ticks. The line is driven low for the first 511 ticks of that time.
- R4: Control bit 6 is set to 1 if `bus_in` is low during tick 581 of the reset sequence, which is 70 ticks after the line is released. It is set to 0 otherwise. The bit keeps its value until the next sample or a soft reset.
- R5: Writing 1 to control bit 5 starts a write-0 slot. Bit 5 reads 1 for 62 ticks, and the line is driven low for the first 60 of them.
- R6: Writing 1 to control bit 4 starts a write-1/read slot. Bit 4 reads 1 for 62 ticks, and the line is driven low for the first 5. Control bit 3 then holds the level of `bus_in` during tick 15.
- R7: When several command bits are written at once, only one action starts. Bit 7 wins over bit 5, and bit 5 wins over bit 4. At most one command bit reads as set at any time.
- R8: A control write that arrives while an action runs changes nothing. The running action keeps its length and no new action follows it.
- R9: Writing 1 to soft-reset bit 0 ends any action in the same cycle, releases the line and clears control bits 6 and 3. While the soft-reset bit stays 1, command writes are ignored. The divider keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register byte address |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| bus_drive_low | output | 1 | 1 = pull the bus line low |
| bus_in | input | 1 | Sampled bus line level |

## Verification
The hardest behaviour to reach from the ports is sampling at exactly one tick. Presence and read data must come from a single tick, so a slave pulse that misses that tick by one must give the opposite result. The bench models the slave as a pull-down whose window is given in ticks. It converts that window to cycles using the divider value under test and sweeps the window edges one tick either side of ticks 581 and 15. Aborting a long reset sequence midway, and issuing command writes in the middle of a slot, are reached by injecting a register write at a chosen cycle inside the monitoring loop of a running action.

// File: rtl/onewire_pkg.sv
package onewire_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_RSTPD = 2'd1,
    OP_WR0   = 2'd2,
    OP_WR1   = 2'd3
  } ow_op_e;

  localparam logic [2:0] ADR_CTRL = 3'h0;
  localparam logic [2:0] ADR_DIV  = 3'h2;
  localparam logic [2:0] ADR_SRST = 3'h4;

  localparam int BIT_RSTPD = 7;
  localparam int BIT_PRES  = 6;
  localparam int BIT_WR0   = 5;
  localparam int BIT_WR1   = 4;
  localparam int BIT_RDV   = 3;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!enable)       cnt_q <= '0;
    else if (cnt_q == div)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = enable && (cnt_q == div);

  // Ticks are spaced by div+1 cycles: with div > 0 two ticks never touch.
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
  import onewire_pkg::*;
#(
  parameter int T_RST_LOW    = 511,
  parameter int T_RST_TOTAL  = 1023,
  parameter int T_PRES_SMP   = 581,
  parameter int T_W0_LOW     = 60,
  parameter int T_W1_LOW     = 5,
  parameter int T_RD_SMP     = 15,
  parameter int T_SLOT_TOTAL = 62
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   abort,
  input  logic   start,
  input  ow_op_e start_op,
  input  logic   tick,
  output ow_op_e cur_op,
  output logic   busy,
  output logic   drive_low,
  output logic   smp_stb
);
  localparam int MAX_T = (T_RST_TOTAL > T_SLOT_TOTAL) ? T_RST_TOTAL : T_SLOT_TOTAL;
  localparam int CNT_W = $clog2(MAX_T + 1);

  ow_op_e           op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c, low_c, smp_c;
  logic             has_smp_c;

  always_comb begin
    last_c    = '0;
    low_c     = '0;
    smp_c     = '0;
    has_smp_c = 1'b0;
    case (op_q)
      OP_RSTPD: begin
        last_c    = CNT_W'(T_RST_TOTAL - 1);
        low_c     = CNT_W'(T_RST_LOW);
        smp_c     = CNT_W'(T_PRES_SMP);
        has_smp_c = 1'b1;
      end
      OP_WR0: begin
        last_c = CNT_W'(T_SLOT_TOTAL - 1);
        low_c  = CNT_W'(T_W0_LOW);
      end
      OP_WR1: begin
        last_c    = CNT_W'(T_SLOT_TOTAL - 1);
        low_c     = CNT_W'(T_W1_LOW);
        smp_c     = CNT_W'(T_RD_SMP);
        has_smp_c = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (abort) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (op_q == OP_IDLE) begin
      cnt_q <= '0;
      if (start) op_q <= start_op;
    end else if (tick) begin
      if (cnt_q == last_c) begin
        op_q  <= OP_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cur_op    = op_q;
  assign busy      = (op_q != OP_IDLE);
  assign drive_low = busy && (cnt_q < low_c);
  assign smp_stb   = tick && has_smp_c && (cnt_q == smp_c);

  // R3 the tick counter never runs past the end of the running action
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= last_c));
  // R5 every action begins by pulling the line low
  assert_low_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> drive_low);
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import onewire_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int T_RST_LOW    = 511,
  parameter int T_RST_TOTAL  = 1023,
  parameter int T_PRES_SMP   = 581,
  parameter int T_W0_LOW     = 60,
  parameter int T_W1_LOW     = 5,
  parameter int T_RD_SMP     = 15,
  parameter int T_SLOT_TOTAL = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_drive_low,
  input  logic       bus_in
);
  localparam int DATA_W = 8;

  logic [DIV_W-1:0] div_q;
  logic             srst_q, pres_q, rdv_q;
  logic             tick, busy, smp_stb, start, abort, cmd_wr;
  ow_op_e           cur_op, start_op;

  assign cmd_wr = reg_wr_en && (reg_addr == ADR_CTRL);
  assign abort  = srst_q || (reg_wr_en && reg_addr == ADR_SRST && reg_wdata[0]);
  assign start  = cmd_wr && !busy && !abort &&
                  (reg_wdata[BIT_RSTPD] || reg_wdata[BIT_WR0] || reg_wdata[BIT_WR1]);

  always_comb begin
    if (reg_wdata[BIT_RSTPD])    start_op = OP_RSTPD;
    else if (reg_wdata[BIT_WR0]) start_op = OP_WR0;
    else                         start_op = OP_WR1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      srst_q <= 1'b0;
      pres_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == ADR_DIV)  div_q  <= reg_wdata[DIV_W-1:0];
      if (reg_wr_en && reg_addr == ADR_SRST) srst_q <= reg_wdata[0];
      if (abort) begin
        pres_q <= 1'b0;
        rdv_q  <= 1'b0;
      end else if (smp_stb) begin
        if (cur_op == OP_RSTPD) pres_q <= !bus_in;
        else                    rdv_q  <= bus_in;
      end
    end
  end

  ow_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (busy),
    .div    (div_q),
    .tick   (tick)
  );

  ow_slot_seq #(
    .T_RST_LOW    (T_RST_LOW),
    .T_RST_TOTAL  (T_RST_TOTAL),
    .T_PRES_SMP   (T_PRES_SMP),
    .T_W0_LOW     (T_W0_LOW),
    .T_W1_LOW     (T_W1_LOW),
    .T_RD_SMP     (T_RD_SMP),
    .T_SLOT_TOTAL (T_SLOT_TOTAL)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .start     (start),
    .start_op  (start_op),
    .tick      (tick),
    .cur_op    (cur_op),
    .busy      (busy),
    .drive_low (bus_drive_low),
    .smp_stb   (smp_stb)
  );

  logic [DATA_W-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[BIT_RSTPD] = (cur_op == OP_RSTPD);
    ctrl_rd[BIT_PRES]  = pres_q;
    ctrl_rd[BIT_WR0]   = (cur_op == OP_WR0);
    ctrl_rd[BIT_WR1]   = (cur_op == OP_WR1);
    ctrl_rd[BIT_RDV]   = rdv_q;
  end

  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = ctrl_rd;
      ADR_DIV:  reg_rdata = DATA_W'(div_q);
      ADR_SRST: reg_rdata = {{(DATA_W-1){1'b0}}, srst_q};
      default:  reg_rdata = '0;
    endcase
  end

  // R7 at most one command bit reads as set
  assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_rd[BIT_RSTPD], ctrl_rd[BIT_WR0], ctrl_rd[BIT_WR1]}));
  // R8 a command write during an action leaves the action unchanged
  assert_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (cur_op == $past(cur_op) || cur_op == OP_IDLE));
  // R9 a held soft reset keeps the block idle and the line released
  assert_srst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (!busy && !bus_drive_low));
endmodule

// File: tb/onewire_master_bench.sv
`timescale 1ns/1ps
module onewire_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = 3'h0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bus_drive_low;
  logic       slave_low = 1'b0;
  logic       bus_in;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  assign bus_in = !(bus_drive_low || slave_low);

  onewire_master u_onewire_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .bus_drive_low (bus_drive_low),
    .bus_in        (bus_in)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 3'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 3'h0;
  endtask

  // Start cmd; slave pulls low during ticks slo..shi; optional write at cycle mid_k.
  task automatic run_op(input logic [7:0] cmd, input int d, input int slo, input int shi,
                        input int mid_k, input logic [2:0] mid_a, input logic [7:0] mid_d,
                        output int busy_n, output int low_n);
    int k;
    busy_n = 0; low_n = 0; k = 0;
    @(negedge clk);
    reg_addr = 3'h0; reg_wdata = cmd; reg_wr_en = 1'b1;
    while (k < 20000) begin
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 3'h0;
      slave_low = ((k / (d + 1)) >= slo) && ((k / (d + 1)) <= shi);
      #1;
      if (bus_drive_low) low_n++;
      if ((reg_rdata & 8'hB0) != 8'h00) busy_n++;
      else break;
      if (k == mid_k) begin
        reg_addr = mid_a; reg_wdata = mid_d; reg_wr_en = 1'b1;
      end
      k++;
    end
    slave_low = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int bn, ln;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and address decode
    rd(3'h0, v); check("R1 ctrl reset", v, 0);
    rd(3'h2, v); check("R1 div reset", v, 0);
    rd(3'h4, v); check("R1 srst reset", v, 0);
    wr(3'h1, 8'hFF); rd(3'h1, v); check("R1 unmapped", v, 0);
    wr(3'h2, 8'h03); rd(3'h2, v); check("R1 div readback", v, 3);

    // R2 sweep of the divider with every action
    for (int d = 0; d < 4; d++) begin
      wr(3'h2, 8'(d));
      run_op(8'h80, d, 520, 700, -1, 3'h0, 8'h00, bn, ln);
      check("R3 R2 reset busy", bn, 1023 * (d + 1));
      check("R3 reset low", ln, 511 * (d + 1));
      rd(3'h0, v); check("R4 presence seen", v[6], 1);
      run_op(8'h80, d, 5000, 5000, -1, 3'h0, 8'h00, bn, ln);
      rd(3'h0, v); check("R4 no presence", v[6], 0);
      run_op(8'h20, d, 5000, 5000, -1, 3'h0, 8'h00, bn, ln);
      check("R5 R2 wr0 busy", bn, 62 * (d + 1));
      check("R5 wr0 low", ln, 60 * (d + 1));
      run_op(8'h10, d, 10, 30, -1, 3'h0, 8'h00, bn, ln);
      check("R6 R2 wr1 busy", bn, 62 * (d + 1));
      check("R6 wr1 low", ln, 5 * (d + 1));
      rd(3'h0, v); check("R6 read zero", v[3], 0);
      run_op(8'h10, d, 5000, 5000, -1, 3'h0, 8'h00, bn, ln);
      rd(3'h0, v); check("R6 read one", v[3], 1);
    end

    // R4 / R6 sample-tick boundaries
    wr(3'h2, 8'h00);
    run_op(8'h80, 0, 581, 581, -1, 3'h0, 8'h00, bn, ln);
    rd(3'h0, v); check("R4 pulse at 581", v[6], 1);
    run_op(8'h80, 0, 582, 700, -1, 3'h0, 8'h00, bn, ln);
    rd(3'h0, v); check("R4 pulse after 581", v[6], 0);
    run_op(8'h80, 0, 511, 580, -1, 3'h0, 8'h00, bn, ln);
    rd(3'h0, v); check("R4 pulse before 581", v[6], 0);
    run_op(8'h10, 0, 15, 15, -1, 3'h0, 8'h00, bn, ln);
    rd(3'h0, v); check("R6 low at 15", v[3], 0);
    run_op(8'h10, 0, 16, 40, -1, 3'h0, 8'h00, bn, ln);
    rd(3'h0, v); check("R6 low after 15", v[3], 1);
    run_op(8'h10, 0, 0, 14, -1, 3'h0, 8'h00, bn, ln);
    rd(3'h0, v); check("R6 low before 15", v[3], 1);

    // R7 priority
    run_op(8'hB0, 0, 5000, 5000, -1, 3'h0, 8'h00, bn, ln);
    check("R7 reset wins", ln, 511);
    run_op(8'h30, 0, 5000, 5000, -1, 3'h0, 8'h00, bn, ln);
    check("R7 wr0 wins", ln, 60);

    // R8 command during a slot
    run_op(8'h10, 0, 5000, 5000, 3, 3'h0, 8'h80, bn, ln);
    check("R8 slot length kept", bn, 62);
    check("R8 slot low kept", ln, 5);
    @(negedge clk); #1;
    check("R8 nothing follows", reg_rdata & 8'hB0, 0);
    check("R8 line released", bus_drive_low, 0);

    // R9 soft reset mid-sequence
    wr(3'h2, 8'h01);
    run_op(8'h80, 1, 520, 700, -1, 3'h0, 8'h00, bn, ln);
    run_op(8'h80, 1, 5000, 5000, 100, 3'h4, 8'h01, bn, ln);
    check("R9 abort cycle", bn, 101);
    check("R9 low until abort", ln, 101);
    rd(3'h0, v); check("R9 ctrl cleared", v, 0);
    wr(3'h0, 8'h80);
    @(negedge clk); #1;
    check("R9 cmd ignored held", reg_rdata, 0);
    check("R9 line idle held", bus_drive_low, 0);
    rd(3'h2, v); check("R9 divider kept", v, 1);
    wr(3'h4, 8'h00);
    run_op(8'h20, 1, 5000, 5000, -1, 3'h0, 8'h00, bn, ln);
    check("R9 works after release", ln, 120);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule